// File: doc/BRIEF.md
# PLL Clock Mode and Fault Supervisor

This block is the digital control wrapped around a phase-locked loop. Software picks one of three clock operating modes: PLL unpowered with the crystal as system clock, PLL powered but still bypassed, or PLL output driving the system clock. The block debounces the raw lock indicator and watches two clock-quality indicators, one for the crystal and one for the PLL output. It reacts to each fault according to that fault's own policy bit.

Loss of lock and a bad crystal each raise either a sticky interrupt flag or a one-cycle reset request. A bad PLL output clock either requests a reset or moves the system clock back to the crystal and raises a flag. When the crystal fallback is taken, the PLL stays deselected until software writes the mode again. Loss of the reference clock switches the clock mux to a self-clocked source. The analog loop and the frequency measurement that produce the indicator inputs are outside this block.

Top module: `pll_supervisor`

## Requirements
- R1: After reset the block is in bypass with the PLL powered: `pll_pwr_en`=1, `clk_sel`=0 (crystal), `locked`=0, `flags`=0, `irq`=0, `rst_req`=0, `rst_cause`=0.
- R2: Writing the mode (`mode_wr`=1) takes effect at the next edge, with code 0 = PLL off, 1 = bypass with PLL running, 2 = PLL drives the clock. Code 3 is ignored. `pll_pwr_en` is 0 only in mode 0.
- R3: `locked` rises only after `lock_raw` has been 1 on 16 consecutive clock edges while the PLL is powered. Any 0 restarts the count.
- R4: While the PLL is powered and `locked`=1, a 0 on `lock_raw` clears `locked` at the next edge and counts as a loss-of-lock event. Powering the PLL down clears `locked` without raising any event.
- R5: On a loss-of-lock event, `lol_rst_en`=0 sets flag bit 0 and `lol_rst_en`=1 pulses `rst_req` with cause 1.
- R6: A crystal fault is the rising edge of `xtal_ok`=0. `xtal_rst_en`=0 sets flag bit 1 and `xtal_rst_en`=1 pulses `rst_req` with cause 2. A crystal that stays bad raises no further event.
- R7: A PLL-clock fault is the rising edge of `pllclk_ok`=0 while the PLL is powered. `pll_rst_en`=1 pulses `rst_req` with cause 3. `pll_rst_en`=0 sets flag bit 2 and forces the crystal fallback.
- R8: The crystal fallback persists, even after the PLL clock recovers, until a valid mode write. A fallback fault in the same cycle as a mode write wins over the write.
- R9: `clk_sel` is 2 (self-clocked) when `scm`=1. Otherwise it is 1 (PLL) only in mode 2 with `locked`=1 and no fallback. Otherwise it is 0 (crystal).
- R10: Flags are sticky and cleared by writing 1 to the matching bit of `flag_clr`. A flag set in the same cycle as its clear stays set.
- R11: `irq` is registered and equals the OR of `flags & irq_en`, using the flag values and `irq_en` seen at the same edge.
- R12: `rst_req` is high for one cycle per reset-policy fault. `rst_cause` holds the last cause (1 loss of lock, 2 crystal, 3 PLL clock), and on simultaneous faults the higher code wins.
- R13: `scm` follows `ref_lost` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 2 | Mode code to write |
| lock_raw | input | 1 | Raw lock indicator from the PLL |
| xtal_ok | input | 1 | Crystal clock quality good |
| pllclk_ok | input | 1 | PLL output clock quality good |
| ref_lost | input | 1 | Reference clock lost indicator |
| lol_rst_en | input | 1 | Loss-of-lock policy: 1 reset, 0 interrupt |
| xtal_rst_en | input | 1 | Crystal fault policy: 1 reset, 0 interrupt |
| pll_rst_en | input | 1 | PLL clock fault policy: 1 reset, 0 fallback and interrupt |
| irq_en | input | 3 | Per-flag interrupt enables |
| flag_clr | input | 3 | Write-1-to-clear strobes for the flags |
| pll_pwr_en | output | 1 | PLL power enable |
| clk_sel | output | 2 | System clock mux select |
| locked | output | 1 | Filtered lock status |
| scm | output | 1 | Self-clocked mode indication |
| flags | output | 3 | Sticky fault flags (0 loss of lock, 1 crystal, 2 PLL clock) |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Latched cause of the last reset request |

## Verification
The lock filter gets a run that is one edge short and contains a glitch, followed by a full run. This separates a filter that counts consecutive edges from one that counts total high edges. Each fault source is fired once under each policy value, and held bad across a flag clear. That shows whether the events are edge-based and whether each policy bit steers only its own fault. The fallback is stressed by recovering the PLL clock without a mode write, and by a fault that lands in the same cycle as a write, which reveals which one the design lets win. Mode changes to power-down and to bypass check that no false loss-of-lock event appears and that a lock alone never selects the PLL outside normal mode.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_BYP  = 2'd1,
    MODE_NORM = 2'd2
  } pll_mode_e;

  localparam logic [1:0] SEL_XTAL = 2'd0;
  localparam logic [1:0] SEL_PLL  = 2'd1;
  localparam logic [1:0] SEL_SCM  = 2'd2;

  localparam int NFLAG   = 3;
  localparam int FL_LOL  = 0;
  localparam int FL_XTAL = 1;
  localparam int FL_PCLK = 2;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_LOL  = 2'd1;
  localparam logic [1:0] CAUSE_XTAL = 2'd2;
  localparam logic [1:0] CAUSE_PCLK = 2'd3;
endpackage

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
  parameter int LOCK_CNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_en,
  input  logic lock_raw,
  output logic locked,
  output logic loss_evt
);
  localparam int CW = (LOCK_CNT > 1) ? $clog2(LOCK_CNT) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(LOCK_CNT - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (!pwr_en || !lock_raw) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (run_cnt == CNT_TOP) begin
      locked  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // loss is only meaningful while the loop is powered and was locked
  assign loss_evt = locked & ~lock_raw & pwr_en;

  // R3: lock can only be declared on an edge that saw the raw lock high
  p_acq_needs_raw_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(lock_raw) && $past(pwr_en));

  // R4: powering the PLL down drops the lock at the following edge
  p_off_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> !locked);

  // R4: a loss event is always followed by an unlocked state
  p_loss_drops_r4: assert property (@(posedge clk) disable iff (rst)
    loss_evt |=> !locked);
endmodule

// File: rtl/pll_fault_ctrl.sv
module pll_fault_ctrl
  import pll_sup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic             loss_evt,
  input  logic             xtal_ok,
  input  logic             pllclk_ok,
  input  logic             lol_rst_en,
  input  logic             xtal_rst_en,
  input  logic             pll_rst_en,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             rst_req,
  output logic [1:0]       rst_cause,
  output logic             fallback_set
);
  logic             xbad_q, pbad_q;
  logic             xbad, pbad, x_evt, p_evt;
  logic             lol_hit, x_hit, p_hit;
  logic [NFLAG-1:0] set_vec, flags_nxt;

  assign xbad  = ~xtal_ok;
  assign pbad  = pwr_en & ~pllclk_ok;
  assign x_evt = xbad & ~xbad_q;
  assign p_evt = pbad & ~pbad_q;

  assign lol_hit = loss_evt & lol_rst_en;
  assign x_hit   = x_evt & xtal_rst_en;
  assign p_hit   = p_evt & pll_rst_en;

  always_comb begin
    set_vec          = '0;
    set_vec[FL_LOL]  = loss_evt & ~lol_rst_en;
    set_vec[FL_XTAL] = x_evt & ~xtal_rst_en;
    set_vec[FL_PCLK] = p_evt & ~pll_rst_en;
    flags_nxt        = (flags & ~flag_clr) | set_vec;
  end

  assign fallback_set = set_vec[FL_PCLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      xbad_q    <= 1'b0;
      pbad_q    <= 1'b0;
      flags     <= '0;
      irq       <= 1'b0;
      rst_req   <= 1'b0;
      rst_cause <= CAUSE_NONE;
    end else begin
      xbad_q  <= xbad;
      pbad_q  <= pbad;
      flags   <= flags_nxt;
      irq     <= |(flags_nxt & irq_en);
      rst_req <= lol_hit | x_hit | p_hit;
      if (p_hit)        rst_cause <= CAUSE_PCLK;
      else if (x_hit)   rst_cause <= CAUSE_XTAL;
      else if (lol_hit) rst_cause <= CAUSE_LOL;
    end
  end

  // R12: every reset request comes with a recorded cause
  p_cause_valid_r12: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rst_cause != CAUSE_NONE);

  // R10: a flag not being cleared survives to the next cycle
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

  // R6: a crystal that stays bad never produces back-to-back events
  p_xtal_edge_r6: assert property (@(posedge clk) disable iff (rst)
    x_evt |=> !x_evt);
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  input  logic       locked,
  input  logic       fallback_set,
  input  logic       ref_lost,
  output logic       pwr_en,
  output logic [1:0] clk_sel,
  output logic       scm
);
  pll_mode_e mode_q;
  logic      fb_q;
  logic      wr_ok;

  assign wr_ok = mode_wr && (mode_sel != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BYP;
      fb_q   <= 1'b0;
      scm    <= 1'b0;
    end else begin
      scm <= ref_lost;
      if (wr_ok) mode_q <= pll_mode_e'(mode_sel);
      if (fallback_set)  fb_q <= 1'b1;
      else if (wr_ok)    fb_q <= 1'b0;
    end
  end

  assign pwr_en = (mode_q != MODE_OFF);

  always_comb begin
    if (scm)                                          clk_sel = SEL_SCM;
    else if (mode_q == MODE_NORM && locked && !fb_q)  clk_sel = SEL_PLL;
    else                                              clk_sel = SEL_XTAL;
  end

  // R9: the PLL is never selected while unpowered
  p_pll_needs_pwr_r9: assert property (@(posedge clk) disable iff (rst)
    clk_sel == SEL_PLL |-> pwr_en && locked);

  // R8: fallback is held until a mode write
  p_fb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    fb_q && !mode_wr |=> fb_q);

  // R13: loss of the reference enters self-clocked mode next cycle
  p_scm_entry_r13: assert property (@(posedge clk) disable iff (rst)
    ref_lost |=> scm && clk_sel == SEL_SCM);
endmodule

// File: rtl/pll_supervisor.sv
module pll_supervisor
  import pll_sup_pkg::*;
#(
  parameter int LOCK_CNT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [1:0]       mode_sel,
  input  logic             lock_raw,
  input  logic             xtal_ok,
  input  logic             pllclk_ok,
  input  logic             ref_lost,
  input  logic             lol_rst_en,
  input  logic             xtal_rst_en,
  input  logic             pll_rst_en,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  output logic             pll_pwr_en,
  output logic [1:0]       clk_sel,
  output logic             locked,
  output logic             scm,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             rst_req,
  output logic [1:0]       rst_cause
);
  logic loss_evt;
  logic fallback_set;

  pll_lock_filter #(.LOCK_CNT(LOCK_CNT)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .pwr_en   (pll_pwr_en),
    .lock_raw (lock_raw),
    .locked   (locked),
    .loss_evt (loss_evt)
  );

  pll_fault_ctrl u_fault (
    .clk          (clk),
    .rst          (rst),
    .pwr_en       (pll_pwr_en),
    .loss_evt     (loss_evt),
    .xtal_ok      (xtal_ok),
    .pllclk_ok    (pllclk_ok),
    .lol_rst_en   (lol_rst_en),
    .xtal_rst_en  (xtal_rst_en),
    .pll_rst_en   (pll_rst_en),
    .irq_en       (irq_en),
    .flag_clr     (flag_clr),
    .flags        (flags),
    .irq          (irq),
    .rst_req      (rst_req),
    .rst_cause    (rst_cause),
    .fallback_set (fallback_set)
  );

  pll_mode_ctrl u_mode (
    .clk          (clk),
    .rst          (rst),
    .mode_wr      (mode_wr),
    .mode_sel     (mode_sel),
    .locked       (locked),
    .fallback_set (fallback_set),
    .ref_lost     (ref_lost),
    .pwr_en       (pll_pwr_en),
    .clk_sel      (clk_sel),
    .scm          (scm)
  );

  // R11: an interrupt implies at least one flag is present
  p_irq_has_flag_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> flags != '0);

  // R2: the clock cannot come from the PLL while it is unpowered
  p_off_no_pll_r2: assert property (@(posedge clk) disable iff (rst)
    !pll_pwr_en |-> clk_sel != SEL_PLL);
endmodule

// File: tb/test_pll_supervisor.sv
module test_pll_supervisor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       lock_raw = 1'b0;
  logic       xtal_ok = 1'b1;
  logic       pllclk_ok = 1'b1;
  logic       ref_lost = 1'b0;
  logic       lol_rst_en = 1'b0;
  logic       xtal_rst_en = 1'b0;
  logic       pll_rst_en = 1'b0;
  logic [2:0] irq_en = 3'b111;
  logic [2:0] flag_clr = 3'b000;
  logic       pll_pwr_en, locked, scm, irq, rst_req;
  logic [1:0] clk_sel, rst_cause;
  logic [2:0] flags;

  pll_supervisor i_pll_supervisor (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .lock_raw(lock_raw), .xtal_ok(xtal_ok), .pllclk_ok(pllclk_ok),
    .ref_lost(ref_lost), .lol_rst_en(lol_rst_en), .xtal_rst_en(xtal_rst_en),
    .pll_rst_en(pll_rst_en), .irq_en(irq_en), .flag_clr(flag_clr),
    .pll_pwr_en(pll_pwr_en), .clk_sel(clk_sel), .locked(locked), .scm(scm),
    .flags(flags), .irq(irq), .rst_req(rst_req), .rst_cause(rst_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  task automatic cmp(input int act, input int exp, input string tag, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode, m_cnt, m_cause;
  bit m_fb, m_locked, m_xq, m_pq, m_rst_req, m_scm, m_irq;
  bit [2:0] m_flags;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 1; m_fb = 0; m_cnt = 0; m_locked = 0; m_flags = 0;
      m_xq = 0; m_pq = 0; m_rst_req = 0; m_cause = 0; m_scm = 0; m_irq = 0;
    end else begin
      bit pwr, lol_ev, xb, pb, x_ev, p_ev, lh, xh, ph;
      bit [2:0] setv;
      pwr    = (m_mode != 0);
      lol_ev = m_locked && !lock_raw && pwr;
      xb     = !xtal_ok;
      pb     = pwr && !pllclk_ok;
      x_ev   = xb && !m_xq;
      p_ev   = pb && !m_pq;
      if (!pwr || !lock_raw) begin m_cnt = 0; m_locked = 0; end
      else if (m_cnt == 15) m_locked = 1;
      else m_cnt = m_cnt + 1;
      setv = {p_ev && !pll_rst_en, x_ev && !xtal_rst_en, lol_ev && !lol_rst_en};
      m_flags = (m_flags & ~flag_clr) | setv;
      m_irq = |(m_flags & irq_en);
      lh = lol_ev && lol_rst_en; xh = x_ev && xtal_rst_en; ph = p_ev && pll_rst_en;
      m_rst_req = lh || xh || ph;
      if (ph) m_cause = 3; else if (xh) m_cause = 2; else if (lh) m_cause = 1;
      if (mode_wr && mode_sel != 2'd3) begin m_mode = int'(mode_sel); m_fb = 0; end
      if (setv[2]) m_fb = 1;
      m_xq = xb; m_pq = pb; m_scm = ref_lost;
    end
    started = 1;
  end

  function automatic int m_sel();
    if (m_scm) return 2;
    if (m_mode == 2 && m_locked && !m_fb) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      cmp(int'(pll_pwr_en), int'(m_mode != 0), "R2", "pll_pwr_en");
      cmp(int'(clk_sel), m_sel(), "R9", "clk_sel");
      cmp(int'(locked), int'(m_locked), "R3", "locked");
      cmp(int'(flags), int'(m_flags), "R10", "flags");
      cmp(int'(irq), int'(m_irq), "R11", "irq");
      cmp(int'(rst_req), int'(m_rst_req), "R12", "rst_req");
      cmp(int'(rst_cause), m_cause, "R12", "rst_cause");
      cmp(int'(scm), int'(m_scm), "R13", "scm");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [1:0] code);
    mode_wr = 1'b1; mode_sel = code; step(1); mode_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3); rst = 1'b0;
    // R1 reset state
    cmp(pll_pwr_en, 1, "R1", "pwr after reset");
    cmp(clk_sel, 0, "R1", "sel after reset");
    cmp(flags, 0, "R1", "flags after reset");
    cmp(rst_cause, 0, "R1", "cause after reset");
    cmp(locked, 0, "R1", "locked after reset");
    // R3 filter: 15 edges is too short, glitch restarts
    lock_raw = 1'b1; step(15);
    cmp(locked, 0, "R3", "locked after 15");
    lock_raw = 1'b0; step(1); lock_raw = 1'b1; step(15);
    cmp(locked, 0, "R3", "locked after glitch+15");
    step(1);
    cmp(locked, 1, "R3", "locked after 16");
    // R9 normal mode selects PLL
    wr_mode(2'd2);
    cmp(clk_sel, 1, "R9", "sel in normal");
    // R2 code 3 ignored
    wr_mode(2'd3);
    cmp(clk_sel, 1, "R2", "sel after code 3");
    cmp(pll_pwr_en, 1, "R2", "pwr after code 3");
    // R5 loss of lock, interrupt policy
    lock_raw = 1'b0; step(1); lock_raw = 1'b1;
    cmp(locked, 0, "R4", "locked after loss");
    cmp(flags[0], 1, "R5", "lol flag");
    cmp(irq, 1, "R11", "irq on lol");
    cmp(clk_sel, 0, "R9", "sel after loss");
    flag_clr = 3'b001; step(1); flag_clr = 3'b000;
    cmp(flags, 0, "R10", "flags after clear");
    step(15);
    cmp(locked, 1, "R3", "relock");
    // R5 loss of lock, reset policy
    lol_rst_en = 1'b1; lock_raw = 1'b0; step(1); lock_raw = 1'b1;
    cmp(rst_req, 1, "R5", "rst_req on lol");
    cmp(rst_cause, 1, "R12", "cause lol");
    cmp(flags[0], 0, "R5", "no lol flag in reset policy");
    step(1);
    cmp(rst_req, 0, "R12", "rst_req one cycle");
    lol_rst_en = 1'b0; step(15);
    // R6 crystal fault, interrupt policy, edge-based
    xtal_ok = 1'b0; step(1);
    cmp(flags[1], 1, "R6", "xtal flag");
    step(3); flag_clr = 3'b010; step(1); flag_clr = 3'b000; step(2);
    cmp(flags[1], 0, "R6", "held bad crystal no retrigger");
    xtal_ok = 1'b1; step(1);
    xtal_rst_en = 1'b1; xtal_ok = 1'b0; step(1); xtal_ok = 1'b1;
    cmp(rst_req, 1, "R6", "rst_req on xtal");
    cmp(rst_cause, 2, "R12", "cause xtal");
    xtal_rst_en = 1'b0; step(1);
    // R10 set wins over clear
    xtal_ok = 1'b0; flag_clr = 3'b010; step(1); flag_clr = 3'b000; xtal_ok = 1'b1;
    cmp(flags[1], 1, "R10", "set wins over clear");
    flag_clr = 3'b010; step(1); flag_clr = 3'b000;
    // R11 masking
    irq_en = 3'b101; xtal_ok = 1'b0; step(1); xtal_ok = 1'b1;
    cmp(irq, 0, "R11", "masked flag");
    irq_en = 3'b111; step(1);
    cmp(irq, 1, "R11", "unmasked flag");
    flag_clr = 3'b111; step(1); flag_clr = 3'b000; step(1);
    cmp(clk_sel, 1, "R9", "sel back on PLL");
    // R7 PLL clock fault, fallback policy
    pllclk_ok = 1'b0; step(1); pllclk_ok = 1'b1;
    cmp(flags[2], 1, "R7", "pll clock flag");
    cmp(clk_sel, 0, "R7", "fallback to crystal");
    step(20);
    cmp(clk_sel, 0, "R8", "fallback held after recovery");
    wr_mode(2'd2);
    cmp(clk_sel, 1, "R8", "fallback released by write");
    flag_clr = 3'b100; step(1); flag_clr = 3'b000;
    // R7 reset policy
    pll_rst_en = 1'b1; pllclk_ok = 1'b0; step(1); pllclk_ok = 1'b1;
    cmp(rst_req, 1, "R7", "rst_req on pll clock");
    cmp(rst_cause, 3, "R12", "cause pll clock");
    cmp(clk_sel, 1, "R7", "no fallback in reset policy");
    pll_rst_en = 1'b0; step(1);
    // R8 fault wins over simultaneous write
    pllclk_ok = 1'b0; wr_mode(2'd2); pllclk_ok = 1'b1;
    cmp(clk_sel, 0, "R8", "fault beats write");
    wr_mode(2'd2);
    cmp(clk_sel, 1, "R8", "later write releases");
    flag_clr = 3'b100; step(1); flag_clr = 3'b000;
    // R13 self-clocked mode
    ref_lost = 1'b1; step(1);
    cmp(scm, 1, "R13", "scm entry");
    cmp(clk_sel, 2, "R13", "sel self-clocked");
    ref_lost = 1'b0; step(1);
    cmp(scm, 0, "R13", "scm exit");
    // R2/R4 power down without loss event
    wr_mode(2'd0);
    cmp(pll_pwr_en, 0, "R2", "pwr off");
    step(1);
    cmp(locked, 0, "R4", "unlocked when off");
    lock_raw = 1'b0; step(2);
    cmp(flags, 0, "R4", "no loss event on power down");
    pllclk_ok = 1'b0; step(1);
    cmp(rst_req, 0, "R7", "pll clock ignored when off");
    cmp(flags, 0, "R7", "no pll flag when off");
    pllclk_ok = 1'b1;
    // R9 bypass with lock keeps crystal
    wr_mode(2'd1);
    cmp(pll_pwr_en, 1, "R2", "pwr in bypass");
    lock_raw = 1'b1; step(17);
    cmp(locked, 1, "R3", "lock in bypass");
    cmp(clk_sel, 0, "R9", "bypass keeps crystal");
    step(2);
    finish_run();
  end
endmodule